// File: doc/BRIEF.md
# Prioritized edge-triggered interrupt controller

This block collects interrupt events from six sources and turns them into prioritized requests for a processor core. The sources are four external pins, a one-cycle overflow strobe from a timer, and a change detector on the upper half of an eight-bit input port. Each external pin has its own polarity bit, so it can fire on a rising edge or on a falling edge. Every source owns a sticky flag and an enable bit. All sources except external pin 0 also have a priority bit. Pin 0 always counts as high priority.

The controller drives a high-priority request line and a low-priority request line. Each line is gated by global enables held in a control register. While the core sits in a low-power mode, any pending enabled source raises a wake-up line, whatever the global enables say. A separate vector request is raised only when the master global enable is also set.

Software reaches every field through a small synchronous write port with a combinational read. External pins and port bits are asynchronous to the clock and pass through a two-stage synchronizer before detection.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the flag, enable and priority registers read 0. The control register reads 8'h0F (all polarities rising, both global enables off), and every request output is 0.
- R2: An external pin whose polarity bit (control register bit i for pin i) is 1 sets flag bit i on a rising edge only. With the polarity bit at 0 it sets the flag on a falling edge only. The flag reads 1 in the third clock cycle after the pin changes.
- R3: Clearing an enable bit masks that source's request but neither clears its flag nor stops new events from setting it. Setting the enable again brings the request back.
- R4: A flag stays set until software writes 0 to it at address 0. When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: External pin 0 always counts as high priority. Bit 0 of the priority register reads 0 and ignores writes.
- R6: A one-cycle timer overflow pulse sets flag bit 4 at the next clock edge.
- R7: A change on any of port bits 7..4 sets the shared change flag (bit 5) three cycles later. Changes on port bits 3..0 leave it at 0.
- R8: The high-priority request is 1 exactly when the master enable (control bit 7) is 1 and some source has its flag, its enable and high priority (priority bit 1, or pin 0) all set.
- R9: The low-priority request is 1 exactly when the master enable and the low-priority enable (control bit 6) are both 1 and some source has its flag and enable set with priority bit 0.
- R10: Wake-up equals sleep AND (some source has both flag and enable set), whatever the global enables. The vector request equals wake-up AND the master enable.
- R11: Register layout: address 0 flags, 1 enables, 2 priorities (bits 0..3 the pins, 4 timer, 5 port change, bits 7..6 read 0), 3 control (bits 3..0 polarities, 5..4 read 0). A write replaces the addressed fields at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | External interrupt pins |
| port_i | input | 8 | Port whose upper four bits are watched for changes |
| tmr_ovf_i | input | 1 | One-cycle timer overflow strobe |
| sleep_i | input | 1 | Core is in a low-power mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake-up request to a sleeping core |
| vec_req_o | output | 1 | Branch-to-vector request after wake-up |

## Verification
The bench builds the block with its defaults: an eight-bit port with the change window starting at bit 4, and two synchronizer stages. These defaults put both halves of the port within reach, so the ignored lower bits can be driven right next to the watched ones. They also fix the pin-to-flag latency at three cycles, which the directed edge tests sample exactly. A random phase mixes register writes, timer pulses and sleep changes, and compares every request line and the read data against a model of the register state. This phase exercises priority splits and global-enable combinations that the directed cases do not list one by one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int EXT_N  = 4;
  localparam int SRC_N  = 6;
  localparam int IDX_TMR = 4;
  localparam int IDX_CHG = 5;

  typedef enum logic [1:0] {
    A_FLAG = 2'd0,
    A_EN   = 2'd1,
    A_PRI  = 2'd2,
    A_CTRL = 2'd3
  } reg_addr_e;

  // pending = flag and enable and selected priority mask
  function automatic logic any_req(input logic [SRC_N-1:0] flg,
                                   input logic [SRC_N-1:0] ena,
                                   input logic [SRC_N-1:0] sel);
    return |(flg & ena & sel);
  endfunction

  // sticky update: software value first, hardware set wins
  function automatic logic [SRC_N-1:0] flag_next(input logic [SRC_N-1:0] cur,
                                                 input logic               sw_wr,
                                                 input logic [SRC_N-1:0] sw_val,
                                                 input logic [SRC_N-1:0] hw);
    return (sw_wr ? sw_val : cur) | hw;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit[i] = rise_sel[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]);
  end
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic         chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign chg = |(lvl ^ prev);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CHG_LO = 4,
  parameter int SYNC_N = 2,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [irq_pkg::EXT_N-1:0]  ext_pin_i,
  input  logic [PORT_W-1:0]          port_i,
  input  logic                       tmr_ovf_i,
  input  logic                       sleep_i,
  input  logic                       wr_en_i,
  input  logic [1:0]                 addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       irq_hi_o,
  output logic                       irq_lo_o,
  output logic                       wake_o,
  output logic                       vec_req_o
);
  localparam int CHG_W = PORT_W - CHG_LO;

  // named internal events
  logic [EXT_N-1:0] ext_sync, ext_hit;
  logic [CHG_W-1:0] port_sync;
  logic             port_chg;
  logic [SRC_N-1:0] hw_set;
  logic [SRC_N-1:0] flag_q, en_q, hi_mask;
  logic [SRC_N-1:1] pri_q;
  logic [EXT_N-1:0] pol_q;
  logic             gie_q, gil_q;
  logic             flag_wr;
  logic             any_pend;
  logic             unused_port_lo;

  assign unused_port_lo = ^port_i[CHG_LO-1:0];

  irq_sync #(.W(EXT_N), .STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_i), .q(ext_sync)
  );

  irq_edge_det #(.W(EXT_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ext_sync), .rise_sel(pol_q), .hit(ext_hit)
  );

  irq_sync #(.W(CHG_W), .STAGES(SYNC_N)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_i[PORT_W-1:CHG_LO]), .q(port_sync)
  );

  irq_chg_det #(.W(CHG_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .lvl(port_sync), .chg(port_chg)
  );

  assign hw_set  = {port_chg, tmr_ovf_i, ext_hit};
  assign flag_wr = wr_en_i && (addr_i == A_FLAG);
  assign hi_mask = {pri_q, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      pri_q  <= '0;
      pol_q  <= '1;
      gie_q  <= 1'b0;
      gil_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, flag_wr, wdata_i[SRC_N-1:0], hw_set);
      if (wr_en_i) begin
        case (addr_i)
          A_EN:   en_q  <= wdata_i[SRC_N-1:0];
          A_PRI:  pri_q <= wdata_i[SRC_N-1:1];
          A_CTRL: begin
            pol_q <= wdata_i[EXT_N-1:0];
            gil_q <= wdata_i[DATA_W-2];
            gie_q <= wdata_i[DATA_W-1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_FLAG:  rdata_o[SRC_N-1:0] = flag_q;
      A_EN:    rdata_o[SRC_N-1:0] = en_q;
      A_PRI:   rdata_o[SRC_N-1:0] = {pri_q, 1'b0};
      default: begin
        rdata_o[EXT_N-1:0] = pol_q;
        rdata_o[DATA_W-2]  = gil_q;
        rdata_o[DATA_W-1]  = gie_q;
      end
    endcase
  end

  assign any_pend  = any_req(flag_q, en_q, '1);
  assign irq_hi_o  = gie_q && any_req(flag_q, en_q, hi_mask);
  assign irq_lo_o  = gie_q && gil_q && any_req(flag_q, en_q, ~hi_mask);
  assign wake_o    = sleep_i && any_pend;
  assign vec_req_o = wake_o && gie_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_ovf_i,
  input logic             sleep_i,
  input logic             irq_hi_o,
  input logic             irq_lo_o,
  input logic             wake_o,
  input logic             vec_req_o,
  input logic [SRC_N-1:0] flag_q,
  input logic [SRC_N-1:0] en_q,
  input logic [SRC_N-1:0] hw_set,
  input logic             flag_wr,
  input logic             gie_q,
  input logic             gil_q
);
  // R4
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

  // R6
  tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_q[IDX_TMR]);

  // R5
  int0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && flag_q[0] && en_q[0]) |-> irq_hi_o);

  // R8
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi_o |-> gie_q);

  // R9
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo_o |-> (gie_q && gil_q));

  // R10
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !wake_o);

  // R10
  vec_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> (wake_o && gie_q));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .sleep_i(sleep_i),
  .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .wake_o(wake_o),
  .vec_req_o(vec_req_o), .flag_q(flag_q), .en_q(en_q), .hw_set(hw_set),
  .flag_wr(flag_wr), .gie_q(gie_q), .gil_q(gil_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin = '0;
  logic [7:0] port = '0;
  logic       tmr = 1'b0, sleep = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_hi, irq_lo, wake, vec_req;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of register state
  logic [5:0] m_flag, m_en, m_pri;
  logic [3:0] m_pol;
  logic       m_gie, m_gil;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .port_i(port),
    .tmr_ovf_i(tmr), .sleep_i(sleep), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo),
    .wake_o(wake), .vec_req_o(vec_req)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk); ext_pin[i] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_port(input logic [7:0] v);
    @(negedge clk); port = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // expected read data restated from the register layout
  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_flag};
      2'd1:    return {2'b00, m_en};
      2'd2:    return {2'b00, m_pri[5:1], 1'b0};
      default: return {m_gie, m_gil, 2'b00, m_pol};
    endcase
  endfunction

  function automatic logic m_hi();
    logic [5:0] hp;
    hp = m_pri; hp[0] = 1'b1;
    return m_gie && ((m_flag & m_en & hp) != 6'd0);
  endfunction

  function automatic logic m_lo();
    logic [5:0] lp;
    lp = ~m_pri; lp[0] = 1'b0;
    return m_gie && m_gil && ((m_flag & m_en & lp) != 6'd0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, r); chk("R1 flags", r, 8'h00);
    rd(2'd1, r); chk("R1 enables", r, 8'h00);
    rd(2'd2, r); chk("R1 prio", r, 8'h00);
    rd(2'd3, r); chk("R1 ctrl", r, 8'h0F);
    chk("R1 outputs", {4'h0, irq_hi, irq_lo, wake, vec_req}, 8'h00);

    // R2 polarity
    pin(0, 1'b1); rd(2'd0, r); chk("R2 rise sets", r, 8'h01);
    wr(2'd0, 8'h00);
    pin(0, 1'b0); rd(2'd0, r); chk("R2 fall ignored when rising", r, 8'h00);
    wr(2'd3, 8'h0E);
    pin(0, 1'b1); rd(2'd0, r); chk("R2 rise ignored when falling", r, 8'h00);
    pin(0, 1'b0); rd(2'd0, r); chk("R2 fall sets", r, 8'h01);
    wr(2'd0, 8'h00);
    pin(3, 1'b1); rd(2'd0, r); chk("R2 pin3 rise", r, 8'h08);
    pin(3, 1'b0); wr(2'd0, 8'h00);
    wr(2'd3, 8'h0F);

    // R11 readback of control with unused bits written
    wr(2'd3, 8'hFA); rd(2'd3, r); chk("R11 ctrl readback", r, 8'hCA);
    wr(2'd3, 8'h0F);

    // R5 priority bit 0 forced low, pin 0 still high priority
    wr(2'd2, 8'h3F); rd(2'd2, r); chk("R5 prio bit0 reads 0", r, 8'h3E);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hCF); wr(2'd1, 8'h01); wr(2'd0, 8'h01);
    #1; chk("R5 int0 high", {6'h0, irq_hi, irq_lo}, 8'h02);

    // R3 enable masking
    wr(2'd1, 8'h00); #1; chk("R3 masked", {7'h0, irq_hi}, 8'h00);
    rd(2'd0, r); chk("R3 flag kept", r, 8'h01);
    wr(2'd1, 8'h01); #1; chk("R3 re-enable", {7'h0, irq_hi}, 8'h01);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R6 timer pulse, and R4 set beats clear
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0;
    rd(2'd0, r); chk("R6 timer flag", r, 8'h10);
    rd(2'd1, r); chk("R3 flag set while disabled", r, 8'h00);
    wr(2'd0, 8'h00); rd(2'd0, r); chk("R4 software clear", r, 8'h00);
    @(negedge clk); tmr = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h00;
    @(negedge clk); tmr = 1'b0; wr_en = 1'b0;
    rd(2'd0, r); chk("R4 set wins", r, 8'h10);
    repeat (3) @(negedge clk);
    rd(2'd0, r); chk("R4 sticky", r, 8'h10);
    wr(2'd0, 8'h00);

    // R7 port change
    set_port(8'h0F); rd(2'd0, r); chk("R7 low bits ignored", r, 8'h00);
    set_port(8'h4F); rd(2'd0, r); chk("R7 high bit change", r, 8'h20);
    wr(2'd0, 8'h00);

    // R9 / R8 priority split with INT1
    wr(2'd3, 8'h8F); wr(2'd1, 8'h02); wr(2'd0, 8'h02);
    #1; chk("R9 lo needs low enable", {6'h0, irq_hi, irq_lo}, 8'h00);
    wr(2'd3, 8'hCF); #1; chk("R9 lo request", {6'h0, irq_hi, irq_lo}, 8'h01);
    wr(2'd2, 8'h02); #1; chk("R8 hi request", {6'h0, irq_hi, irq_lo}, 8'h02);

    // R10 wake and vector
    wr(2'd3, 8'h0F); @(negedge clk); sleep = 1'b1; #1;
    chk("R10 wake without gie", {6'h0, wake, vec_req}, 8'h02);
    chk("R8 no hi without gie", {7'h0, irq_hi}, 8'h00);
    wr(2'd3, 8'h8F); #1; chk("R10 vector with gie", {6'h0, wake, vec_req}, 8'h03);
    @(negedge clk); sleep = 1'b0; #1;
    chk("R10 awake no wake", {6'h0, wake, vec_req}, 8'h00);

    // random phase: R8 R9 R10 R11 R4 R6 against model
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h0F);
    m_flag = '0; m_en = '0; m_pri = '0; m_pol = 4'hF; m_gie = 0; m_gil = 0;
    for (int k = 0; k < 400; k++) begin
      logic [5:0] nf;
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      addr  = 2'($urandom);
      wdata = 8'($urandom);
      tmr   = ($urandom % 4) == 0;
      sleep = 1'($urandom);
      #1;
      chk("R11 random read", rdata, m_read(addr));
      chk("R8 random hi", {7'h0, irq_hi}, {7'h0, m_hi()});
      chk("R9 random lo", {7'h0, irq_lo}, {7'h0, m_lo()});
      chk("R10 random wake", {6'h0, wake, vec_req},
          {6'h0, sleep && ((m_flag & m_en) != 0),
                 sleep && m_gie && ((m_flag & m_en) != 0)});
      nf = (wr_en && addr == 2'd0) ? wdata[5:0] : m_flag;
      nf[4] = nf[4] | tmr;
      @(posedge clk);
      m_flag = nf;
      if (wr_en && addr == 2'd1) m_en = wdata[5:0];
      if (wr_en && addr == 2'd2) m_pri = {wdata[5:1], 1'b0};
      if (wr_en && addr == 2'd3) begin
        m_pol = wdata[3:0]; m_gil = wdata[6]; m_gie = wdata[7];
      end
    end
    @(negedge clk); wr_en = 1'b0; tmr = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule